// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked request port and an external asynchronous static RAM of 256K words by 4 bits. It turns each single-word read or write request into a sequence of active-low chip-select, output-enable and write-enable strobes, an 18-bit address and a 4-bit data bus. The data bus is split on the chip side into a drive value, a drive enable and a sampled input, so the pad ring can build the bidirectional pin.

Every timing limit of the memory is a nanosecond parameter. The block divides each limit by the clock period, rounds up, and uses at least one cycle. A write selects the chip and presents the address, lowers write-enable, waits for the memory's outputs to float before driving data, holds the pulse, raises write-enable and releases the bus one cycle later. A read holds chip-select and output-enable low for the access time and then samples the data. Between accesses the chip stays deselected, so the memory can fall into its low-power standby.

Top module: `asram_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `ready` is 1 and `done` is 0.
- R2: A request is taken only while `ready` is 1. A `req` pulse during an access starts no second access and does not change the address in use.
- R3: A read (`req_we`=0) holds `mem_ce_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for the read cycle count, which is 4 cycles by default. `rdata` takes the value of `mem_dq_i` sampled at the end of the last of these cycles.
- R4: During a write, `mem_we_n` is 0 only while `mem_ce_n` is 0 and `mem_oe_n` is 1. `mem_we_n` falls one cycle after `mem_ce_n` falls. `mem_addr` does not change while `mem_ce_n` is 0.
- R5: `mem_dq_oe` is 1 only while `mem_oe_n` is 1. It is 1 only after write-enable has been low for the float count (2 cycles by default), or in the single cycle after write-enable rises.
- R6: Write-enable stays low for the pulse count, which is 4 cycles by default. The data is driven, and stays stable, for at least the setup count (2 cycles by default) before write-enable rises. The controller drives the data value it accepted with the request.
- R7: `mem_ce_n` is 1 in every idle cycle, so consecutive accesses are separated by at least one deselected cycle.
- R8: `done` is a single-cycle pulse. It is seen 7 cycles after the accepting edge for a write and 5 cycles after it for a read with default parameters. `ready` is 1 in the same cycle.
- R9: Data written at any address, including the lowest (0) and highest (0x3FFFF), reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, taken when `ready` is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address of the request |
| req_wdata | input | 4 | Write data |
| ready | output | 1 | Controller is idle and will take a request |
| done | output | 1 | One-cycle pulse when an access completes |
| rdata | output | 4 | Data from the last read |
| mem_addr | output | 18 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 4 | Data to drive onto the memory bus |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 4 | Data sampled from the memory bus |

## Verification
The end of one access and the start of the next can fall in the same cycle. The `done` cycle is also an idle cycle in which `ready` is 1, so a request placed there is accepted at once. The bench provokes this by issuing a write and then a read of the same word with no gap between them. It judges the result by `mem_ce_n` being 1 in the done cycle, by the memory model reporting no overlap of strobes or bus drivers, and by the read returning the word just written. A second collision, a request arriving while an access is still running, is checked by watching the strobes stay idle after the access ends.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and the nanosecond-to-cycle conversion
// used by the asynchronous SRAM controller. Assumes positive clock period.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPUL,
        ST_WHLD,
        ST_RD
    } asram_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        if (ns <= 0) return 1;
        return imax(1, (ns + clk_ns - 1) / clk_ns);
    endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
// Module: asram_timer
// Down counter that times each strobe phase. A load sets the count; it
// then decrements to zero and holds. Also exposes the next-cycle count so
// the caller can register outputs that depend on it.
module asram_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Next count: load wins, otherwise count down and stop at zero.
    always_comb begin
        if (load)
            cnt_nxt = load_val;
        else if (cnt != '0)
            cnt_nxt = cnt - 1'b1;
        else
            cnt_nxt = cnt;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    assign expired = (cnt == '0);

    // R6: phases last exactly their loaded length
    a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
// Module: asram_datapath
// Holds the address and write data of the accepted request for the whole
// access, and captures read data on command. Assumes accept only in idle.
module asram_datapath #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Latch the request fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    // Sample the memory bus at the end of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (capture)
            rdata_q <= dq_in;
    end

    assign mem_addr = addr_q;
    assign dq_out   = wdata_q;
    assign rdata    = rdata_q;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
// Module: asram_ctrl
// Sequences single-word accesses to an asynchronous SRAM. All memory
// strobes come from flops that are loaded from the next-state decode, so they
// carry no decode glitches. Assumes the nanosecond limits are met by whole
// cycles and that pad and board delays fit inside the rounding margin.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 4,
    parameter int CLK_NS    = 4,
    parameter int T_AA_NS   = 15,
    parameter int T_RC_NS   = 15,
    parameter int T_WC_NS   = 15,
    parameter int T_PWE_NS  = 12,
    parameter int T_SCE_NS  = 12,
    parameter int T_SD_NS   = 8,
    parameter int T_HZWE_NS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    // Cycle counts derived from the nanosecond limits.
    localparam int RD_CYC  = imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS));
    localparam int HZ_CYC  = ns2cyc(T_HZWE_NS, CLK_NS);
    localparam int SD_CYC  = ns2cyc(T_SD_NS, CLK_NS);
    localparam int PUL_CYC = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), HZ_CYC + SD_CYC),
                                  imax(ns2cyc(T_SCE_NS, CLK_NS) - 1,
                                       ns2cyc(T_WC_NS, CLK_NS) - 2));
    localparam int CNT_W   = $clog2(imax(RD_CYC, PUL_CYC) + 1) + 1;
    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] PUL_LOAD = CNT_W'(PUL_CYC - 1);
    localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(PUL_CYC - 1 - HZ_CYC);

    asram_state_e     state_q, state_d;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_nxt;
    logic             expired;
    logic             accept;
    logic             capture;
    logic             done_d;

    logic ce_n_q, oe_n_q, we_n_q, dq_oe_q, done_q;

    // Phase timer shared by read and write sequences.
    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .cnt_nxt  (cnt_nxt),
        .expired  (expired)
    );

    // Address, write data and read capture registers.
    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .capture  (capture),
        .dq_in    (mem_dq_i),
        .mem_addr (mem_addr),
        .dq_out   (mem_dq_o),
        .rdata    (rdata)
    );

    // Next-state and phase-timer control.
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        done_d   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (req_we) begin
                        state_d = ST_WSET;
                    end else begin
                        state_d  = ST_RD;
                        load_val = RD_LOAD;
                    end
                end
            end
            ST_WSET: begin
                state_d  = ST_WPUL;
                load     = 1'b1;
                load_val = PUL_LOAD;
            end
            ST_WPUL: begin
                if (expired) state_d = ST_WHLD;
            end
            ST_WHLD: begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            ST_RD: begin
                if (expired) begin
                    state_d = ST_IDLE;
                    capture = 1'b1;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Strobe and bus-enable flops, loaded from the next-state decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            dq_oe_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            ce_n_q  <= (state_d == ST_IDLE);
            oe_n_q  <= (state_d != ST_RD);
            we_n_q  <= (state_d != ST_WPUL);
            dq_oe_q <= ((state_d == ST_WPUL) && (cnt_nxt <= DRV_LAST)) ||
                       (state_d == ST_WHLD);
            done_q  <= done_d;
        end
    end

    assign ready     = (state_q == ST_IDLE);
    assign done      = done_q;
    assign mem_ce_n  = ce_n_q;
    assign mem_oe_n  = oe_n_q;
    assign mem_we_n  = we_n_q;
    assign mem_dq_oe = dq_oe_q;

    // R4: write-enable low only inside chip select
    a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));
    // R4: address held for the whole selected window
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
    // R5: no drive while the memory may drive
    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));
    // R5: the first write-enable-low cycle leaves the bus floating
    a_r5_float_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);
    // R6: data still driven in the cycle after write-enable rises
    a_r6_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_ce_n) |-> mem_dq_oe);
    // R6: bus and chip released one cycle later
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_ce_n) |=> (!mem_dq_oe && mem_ce_n));
    // R7: idle means deselected
    a_r7_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mem_ce_n);
    // R2: no new request while the chip is selected
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !ready);
    // R8: completion pulse lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
// Bench: directed scenarios against a behavioural SRAM model that flags
// strobe-order, timing and contention errors; scoreboard for read-back.
module sim_asram_ctrl;

    localparam int AW = 18;
    localparam int DW = 4;
    localparam int EXP_WR_LAT = 7;   // R8
    localparam int EXP_RD_LAT = 5;   // R8
    localparam int EXP_PULSE  = 4;   // R6
    localparam int EXP_SETUP  = 2;   // R6
    localparam int EXP_FLOAT  = 2;   // R5
    localparam int EXP_ACCESS = 4;   // R3

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready, done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    asram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .done(done), .rdata(rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [DW-1:0] mem [int];
    logic [DW-1:0] exp_mem [int];
    int we_cnt = 0, drv_cnt = 0, rd_cnt = 0, n_reads = 0;
    logic [DW-1:0] last_d = '0;
    logic p_ce_n = 1'b1, p_we_n = 1'b1, p_rd = 1'b0;
    logic [AW-1:0] p_addr = '0;

    wire reading = !mem_ce_n && !mem_oe_n && mem_we_n;
    logic [DW-1:0] mem_word;
    always_comb begin
        mem_word = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
        // data is only valid once the access time has elapsed
        mem_dq_i = reading ? ((rd_cnt >= EXP_ACCESS) ? mem_word : ~mem_word) : '0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n && (mem_ce_n || !mem_oe_n))
                chk(0, "R4 we_low_outside_select", {mem_ce_n, mem_oe_n}, 2'b01);
            if (mem_dq_oe && !mem_oe_n)
                chk(0, "R5 bus_contention", mem_dq_oe, 0);
            if (!mem_ce_n && !p_ce_n && mem_addr != p_addr)
                chk(0, "R4 addr_changed", mem_addr, p_addr);
            if (!mem_we_n && p_ce_n)
                chk(0, "R4 we_with_ce_fall", 0, 1);
            if (!mem_we_n) we_cnt++;
            if (mem_dq_oe && !mem_we_n && we_cnt <= EXP_FLOAT)
                chk(0, "R5 drive_before_float", we_cnt, EXP_FLOAT + 1);
            if (mem_dq_oe && mem_we_n && p_we_n)
                chk(0, "R5 drive_outside_window", 1, 0);
            if (mem_dq_oe && !mem_we_n) begin
                if (drv_cnt > 0 && mem_dq_o != last_d)
                    chk(0, "R6 data_unstable", mem_dq_o, last_d);
                drv_cnt++;
                last_d = mem_dq_o;
            end
            if (mem_we_n && !p_we_n) begin
                chk(we_cnt == EXP_PULSE, "R6 we_pulse_len", we_cnt, EXP_PULSE);
                chk(drv_cnt >= EXP_SETUP, "R6 data_setup", drv_cnt, EXP_SETUP);
                mem[int'(p_addr)] = last_d;
                we_cnt = 0;
                drv_cnt = 0;
            end
            if (reading) begin
                if (!p_rd) n_reads++;
                rd_cnt++;
            end else begin
                if (p_rd)
                    chk(rd_cnt == EXP_ACCESS, "R3 read_strobe_len", rd_cnt, EXP_ACCESS);
                rd_cnt = 0;
            end
            p_ce_n = mem_ce_n;
            p_we_n = mem_we_n;
            p_rd   = reading;
            p_addr = mem_addr;
        end
    end

    // ---------------- access helper ----------------
    task automatic access(input bit w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output int lat);
        while (!ready) @(negedge clk);
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk(ready == 1'b1, "R8 ready_with_done", ready, 1);
        chk(mem_ce_n == 1'b1, "R7 deselected_at_done", mem_ce_n, 1);
        if (w) exp_mem[int'(a)] = d;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat;
        access(1'b1, a, d, lat);
        chk(lat == EXP_WR_LAT, "R8 write_latency", lat, EXP_WR_LAT);
        chk(mem.exists(int'(a)) && mem[int'(a)] == d, "R6 written_value",
            mem.exists(int'(a)) ? mem[int'(a)] : 'hx, d);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int lat;
        access(1'b0, a, '0, lat);
        chk(lat == EXP_RD_LAT, "R8 read_latency", lat, EXP_RD_LAT);
        chk(rdata == exp_mem[int'(a)], "R3 R9 read_data", rdata, exp_mem[int'(a)]);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes_idle",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!mem_dq_oe, "R1 bus_released", mem_dq_oe, 0);
        chk(ready && !done, "R1 ready_no_done", {ready, done}, 2'b10);
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a = AW'(18'h00100 + i * 37);
            do_write(a, DW'(i * 5 + 3));
        end
        for (int i = 0; i < 8; i++) do_read(AW'(18'h00100 + i * 37));
    endtask

    task automatic t_edges();
        do_write(18'h00000, 4'hA);   // R9 lowest
        do_write(18'h3FFFF, 4'h5);   // R9 highest
        do_write(18'h00000, 4'hF);
        do_read(18'h3FFFF);
        do_read(18'h00000);
    endtask

    task automatic t_back_to_back();
        // next request presented in the done cycle of the previous one
        do_write(18'h2AAAA, 4'h6);
        chk(mem_ce_n == 1'b1, "R7 gap_before_next", mem_ce_n, 1);
        do_read(18'h2AAAA);
        do_write(18'h15555, 4'h9);
        do_write(18'h15556, 4'h0);
        do_read(18'h15555);
        do_read(18'h15556);
    endtask

    task automatic t_busy_ignored();
        int reads_before;
        int lat;
        while (!ready) @(negedge clk);
        reads_before = n_reads;
        req = 1'b1; req_we = 1'b1; req_addr = 18'h01234; req_wdata = 4'hC;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 18'h04321; // arrives while busy
        @(negedge clk);
        req = 1'b0;
        chk(mem_addr == 18'h01234, "R2 addr_kept", mem_addr, 18'h01234);
        lat = 3;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == EXP_WR_LAT, "R2 write_unaffected", lat, EXP_WR_LAT);
        exp_mem[int'(18'h01234)] = 4'hC;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(mem_ce_n == 1'b1, "R2 no_second_access", mem_ce_n, 1);
        end
        chk(n_reads == reads_before, "R2 no_read_started", n_reads, reads_before);
        chk(!done, "R8 done_single_cycle", done, 0);
        do_read(18'h01234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_edges();
        t_back_to_back();
        t_busy_ignored();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule